// File: doc/BRIEF.md
# Tag SRAM Burst-Write Command Handler

This block sits behind the contactless front end of a tag and receives command frames that are already decoded into bytes. It looks for the full-buffer write command. That command carries a command byte, a start-address byte, an end-address byte, 64 payload bytes and a two-byte CRC, in that order. The handler writes the payload into its 64-byte SRAM buffer only when every check passes. It then gives a single 4-bit reply.

The write is all-or-nothing. Payload bytes go into a shadow buffer while the frame is arriving. The block copies the shadow buffer into the SRAM in one cycle, and only when the frame has exactly 69 bytes, carries the fixed address pair, has a good CRC, and the tag is active with pass-through enabled. If any check fails, the SRAM is left untouched and a negative acknowledge is returned. The reply comes one cycle after end-of-frame, which is far inside the reader's 5 ms timeout.

A read port lets the rest of the chip read the SRAM contents one byte at a time.

Top module: `sram_burst_write`

## Requirements
- R1: After reset, `rsp_valid` is low and every SRAM byte reads as 8'h00.
- R2: A frame of exactly 69 bytes is accepted when all of the following hold: it starts with 8'hA6, then 8'hF0, then 8'hFF, then 64 payload bytes, then a CRC_A (reflected polynomial 16'h8408, preset 16'h6363, no final inversion) over the first 67 bytes, low byte first; and `passthru_en` and `tag_active` are high in the `rx_eof` cycle. For such a frame, `rsp_code` is 4'hA in the cycle after `rx_eof`, and from that cycle SRAM byte i reads payload byte i.
- R3: A frame that is otherwise valid but has a CRC mismatch is answered with 4'h1, and the SRAM is unchanged.
- R4: A start byte other than 8'hF0, or an end byte other than 8'hFF, is answered with 4'h0, and the SRAM is unchanged.
- R5: A frame starting with 8'hA6 that holds fewer or more than 69 bytes before `rx_eof` is answered with 4'h0, and the SRAM is unchanged.
- R6: If `passthru_en` or `tag_active` is low in the `rx_eof` cycle, a frame starting with 8'hA6 is answered with 4'h0, and the SRAM is unchanged.
- R7: A frame whose first byte is not 8'hA6 produces no reply and leaves the SRAM unchanged.
- R8: `rsp_valid` is high for exactly one cycle, only in the cycle after `rx_eof`, and `rsp_code` is then one of 4'hA, 4'h0 or 4'h1.
- R9: When an argument error (mode, length or address) and a CRC error occur together, the reply is 4'h0.
- R10: A new frame may begin in the cycle right after `rx_eof`. Idle cycles between bytes do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A frame byte is present on `rx_data` |
| rx_data | input | 8 | Frame byte |
| rx_eof | input | 1 | End-of-frame pulse; closes the current frame |
| passthru_en | input | 1 | Pass-through mode is enabled |
| tag_active | input | 1 | Tag is in the active state |
| rd_addr | input | 6 | SRAM read address |
| rd_data | output | 8 | SRAM byte at `rd_addr` |
| rsp_valid | output | 1 | Reply strobe |
| rsp_code | output | 4 | Reply code: 4'hA acknowledge, 4'h0 bad argument, 4'h1 CRC error |

## Verification
The bench builds the handler with its default parameters: a 64-byte buffer, command 8'hA6 and address pair 8'hF0/8'hFF. With these values the real 69-byte frame is used. Both a 68-byte frame and a 70-byte frame reach the length check, and the 70-byte frame also pushes the byte counter into its saturating state. Because the buffer is small enough to read back in full after every frame, the bench can show that rejected frames leave all 64 bytes untouched and that an accepted frame replaces all of them.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
    typedef enum logic [3:0] {
        RSP_NAK_ARG = 4'h0,
        RSP_NAK_CRC = 4'h1,
        RSP_ACK     = 4'hA
    } rsp_e;

    localparam logic [15:0] CRC_PRESET   = 16'h6363;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;
    localparam int          HDR_BYTES    = 3;
    localparam int          TRL_BYTES    = 2;
endpackage

// File: rtl/bwr_crc_step.sv
module bwr_crc_step
    import bwr_pkg::*;
(
    input  logic [15:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [15:0] crc_out
);
    always_comb begin
        logic [15:0] acc;
        acc = crc_in ^ {8'h00, data_in};
        for (int b = 0; b < 8; b++) begin
            if (acc[0]) acc = (acc >> 1) ^ CRC_POLY_REV;
            else        acc = acc >> 1;
        end
        crc_out = acc;
    end
endmodule

// File: rtl/bwr_buffer.sv
module bwr_buffer #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          commit,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] shadow;
        logic [DEPTH-1:0][7:0] store;
    } buf_s;

    buf_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en)  st_d.shadow[wr_idx] = wr_data;
        if (commit) st_d.store = st_q.shadow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.store[rd_addr];
endmodule

// File: rtl/bwr_ctrl.sv
module bwr_ctrl
    import bwr_pkg::*;
#(
    parameter int          DEPTH      = 64,
    parameter logic [7:0]  CMD_CODE   = 8'hA6,
    parameter logic [7:0]  START_PAGE = 8'hF0,
    parameter logic [7:0]  END_PAGE   = 8'hFF,
    localparam int         AW         = $clog2(DEPTH),
    localparam int         FRAME_LEN  = HDR_BYTES + DEPTH + TRL_BYTES,
    localparam int         CW         = $clog2(FRAME_LEN + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_eof,
    input  logic          mode_ok,
    input  logic [15:0]   crc_next,
    output logic [15:0]   crc_cur,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic          commit,
    output logic          rsp_valid,
    output logic [3:0]    rsp_code
);
    localparam logic [CW-1:0] LEN_EXACT = CW'(FRAME_LEN);
    localparam logic [CW-1:0] LEN_OVER  = CW'(FRAME_LEN + 1);
    localparam logic [CW-1:0] DATA_LO   = CW'(HDR_BYTES);
    localparam logic [CW-1:0] DATA_HI   = CW'(HDR_BYTES + DEPTH);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [15:0]   crc;
        logic          cmd_hit;
        logic          addr_ok;
        logic          rsp_valid;
        logic [3:0]    rsp_code;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic [CW-1:0] data_off;

    assign data_off = st_q.cnt - DATA_LO;
    assign crc_cur  = st_q.crc;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        wr_en          = 1'b0;
        wr_idx         = data_off[AW-1:0];
        commit         = 1'b0;
        if (rx_eof) begin
            if (st_q.cmd_hit) begin
                st_d.rsp_valid = 1'b1;
                if (!mode_ok || st_q.cnt != LEN_EXACT || !st_q.addr_ok) begin
                    st_d.rsp_code = RSP_NAK_ARG;
                end else if (st_q.crc != 16'h0000) begin
                    st_d.rsp_code = RSP_NAK_CRC;
                end else begin
                    st_d.rsp_code = RSP_ACK;
                    commit        = 1'b1;
                end
            end
            st_d.cnt     = '0;
            st_d.crc     = CRC_PRESET;
            st_d.cmd_hit = 1'b0;
            st_d.addr_ok = 1'b1;
        end else if (rx_valid) begin
            if (st_q.cnt != LEN_OVER) st_d.cnt = st_q.cnt + 1'b1;
            st_d.crc = crc_next;
            if (st_q.cnt == CW'(0)) st_d.cmd_hit = (rx_data == CMD_CODE);
            if (st_q.cnt == CW'(1) && rx_data != START_PAGE) st_d.addr_ok = 1'b0;
            if (st_q.cnt == CW'(2) && rx_data != END_PAGE)   st_d.addr_ok = 1'b0;
            if (st_q.cnt >= DATA_LO && st_q.cnt < DATA_HI)   wr_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.crc     <= CRC_PRESET;
            st_q.addr_ok <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_code  = st_q.rsp_code;
endmodule

// File: rtl/sram_burst_write.sv
module sram_burst_write #(
    parameter int         DEPTH      = 64,
    parameter logic [7:0] CMD_CODE   = 8'hA6,
    parameter logic [7:0] START_PAGE = 8'hF0,
    parameter logic [7:0] END_PAGE   = 8'hFF,
    localparam int        AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_eof,
    input  logic          passthru_en,
    input  logic          tag_active,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          rsp_valid,
    output logic [3:0]    rsp_code
);
    logic [15:0]   crc_cur, crc_next;
    logic          wr_en, commit;
    logic [AW-1:0] wr_idx;

    bwr_crc_step i_crc (
        .crc_in  (crc_cur),
        .data_in (rx_data),
        .crc_out (crc_next)
    );

    bwr_ctrl #(
        .DEPTH      (DEPTH),
        .CMD_CODE   (CMD_CODE),
        .START_PAGE (START_PAGE),
        .END_PAGE   (END_PAGE)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_eof    (rx_eof),
        .mode_ok   (passthru_en & tag_active),
        .crc_next  (crc_next),
        .crc_cur   (crc_cur),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .commit    (commit),
        .rsp_valid (rsp_valid),
        .rsp_code  (rsp_code)
    );

    bwr_buffer #(.DEPTH(DEPTH)) i_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (rx_data),
        .commit  (commit),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/bwr_checker.sv
module bwr_checker #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_eof,
    input logic          passthru_en,
    input logic          tag_active,
    input logic [AW-1:0] rd_addr,
    input logic [7:0]    rd_data,
    input logic          rsp_valid,
    input logic [3:0]    rsp_code
);
    assert_rsp_follows_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rx_eof));

    assert_rsp_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code == 4'hA || rsp_code == 4'h0 || rsp_code == 4'h1));

    assert_ack_needs_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 4'hA) |-> $past(passthru_en && tag_active));

    assert_store_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_addr) && !(rsp_valid && rsp_code == 4'hA)) |-> $stable(rd_data));
endmodule

bind sram_burst_write bwr_checker #(.AW(AW)) i_bwr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_eof      (rx_eof),
    .passthru_en (passthru_en),
    .tag_active  (tag_active),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code)
);

// File: tb/test_sram_burst_write.sv
module test_sram_burst_write;
    typedef logic [7:0] byte_q_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_eof = 1'b0;
    logic       passthru_en = 1'b1;
    logic       tag_active = 1'b1;
    logic [5:0] rd_addr = 6'd0;
    logic [7:0] rd_data;
    logic       rsp_valid;
    logic [3:0] rsp_code;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    logic [7:0] m_mem[64];
    logic [7:0] m_frame[$];
    logic       m_v = 1'b0;
    logic [3:0] m_c = 4'h0;

    always #5 clk = ~clk;

    sram_burst_write i_sram_burst_write (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eof(rx_eof), .passthru_en(passthru_en), .tag_active(tag_active),
        .rd_addr(rd_addr), .rd_data(rd_data), .rsp_valid(rsp_valid), .rsp_code(rsp_code)
    );

    function automatic logic [15:0] crc_a(byte_q_t q, int n);
        logic [15:0] c = 16'h6363;
        for (int i = 0; i < n; i++) begin
            c ^= {8'h00, q[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return c;
    endfunction

    function automatic byte_q_t build(logic [7:0] cmd, logic [7:0] sa, logic [7:0] ea,
                                      int ndata, int seed, logic [7:0] crc_flip);
        byte_q_t q;
        logic [15:0] c;
        q.push_back(cmd);
        q.push_back(sa);
        q.push_back(ea);
        for (int i = 0; i < ndata; i++) q.push_back(8'((i * 7 + seed * 13 + 5) & 8'hFF));
        c = crc_a(q, q.size());
        q.push_back(c[7:0] ^ crc_flip);
        q.push_back(c[15:8]);
        return q;
    endfunction

    // Behavioural reference: collects the frame and predicts the reply.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_v = 1'b0;
            m_frame.delete();
            for (int i = 0; i < 64; i++) m_mem[i] = 8'h00;
        end else begin
            m_v = 1'b0;
            if (rx_eof) begin
                if (m_frame.size() > 0 && m_frame[0] == 8'hA6) begin
                    m_v = 1'b1;
                    if (!(passthru_en && tag_active) || m_frame.size() != 69 ||
                        m_frame[1] != 8'hF0 || m_frame[2] != 8'hFF)
                        m_c = 4'h0;
                    else if (crc_a(m_frame, 67) != {m_frame[68], m_frame[67]})
                        m_c = 4'h1;
                    else begin
                        m_c = 4'hA;
                        for (int i = 0; i < 64; i++) m_mem[i] = m_frame[3 + i];
                    end
                end
                m_frame.delete();
            end else if (rx_valid) begin
                m_frame.push_back(rx_data);
            end
        end
    end

    // Per-clock reply comparison (R8 plus the tag of the running case).
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (m_v || rsp_valid) begin
                total++;
                if (rsp_valid !== m_v || (m_v && rsp_code !== m_c)) begin
                    bad++;
                    $display("FAIL %s/R8 reply: valid=%0b code=%h expected valid=%0b code=%h",
                             tag, rsp_valid, rsp_code, m_v, m_c);
                end
            end
        end
    end

    task automatic send(byte_q_t q, bit gaps);
        foreach (q[i]) begin
            @(negedge clk);
            rx_eof = 1'b0;
            rx_valid = 1'b1;
            rx_data = q[i];
            if (gaps && (i % 5 == 2)) begin
                @(negedge clk);
                rx_valid = 1'b0;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_eof = 1'b1;
    endtask

    task automatic close_frame();
        @(negedge clk);
        rx_eof = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_mem(string req);
        logic [7:0] got;
        int errs = 0;
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            rd_addr = 6'(a);
            #1;
            got = rd_data;
            if (got !== m_mem[a]) begin
                errs++;
                if (errs == 1)
                    $display("FAIL %s sram[%0d]: got=%h expected=%h", req, a, got, m_mem[a]);
            end
        end
        total++;
        if (errs != 0) bad++;
    endtask

    task automatic run(string req, byte_q_t q, bit gaps);
        tag = req;
        send(q, gaps);
        close_frame();
        check_mem(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        total++;
        if (rsp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 rsp_valid: got=%0b expected=0", rsp_valid);
        end
        check_mem("R1");

        // R2: good frame, contiguous and with gaps (R10)
        run("R2", build(8'hA6, 8'hF0, 8'hFF, 64, 1, 8'h00), 1'b0);
        run("R10", build(8'hA6, 8'hF0, 8'hFF, 64, 2, 8'h00), 1'b1);
        // R3: CRC error
        run("R3", build(8'hA6, 8'hF0, 8'hFF, 64, 3, 8'h01), 1'b0);
        // R4: address errors
        run("R4", build(8'hA6, 8'hF1, 8'hFF, 64, 4, 8'h00), 1'b0);
        run("R4", build(8'hA6, 8'hF0, 8'hFE, 64, 5, 8'h00), 1'b0);
        // R5: wrong length
        run("R5", build(8'hA6, 8'hF0, 8'hFF, 63, 6, 8'h00), 1'b0);
        run("R5", build(8'hA6, 8'hF0, 8'hFF, 65, 7, 8'h00), 1'b0);
        // R6: mode off
        passthru_en = 1'b0;
        run("R6", build(8'hA6, 8'hF0, 8'hFF, 64, 8, 8'h00), 1'b0);
        passthru_en = 1'b1;
        tag_active = 1'b0;
        run("R6", build(8'hA6, 8'hF0, 8'hFF, 64, 9, 8'h00), 1'b0);
        tag_active = 1'b1;
        // R7: other command
        run("R7", build(8'h30, 8'hF0, 8'hFF, 64, 10, 8'h00), 1'b0);
        // R9: argument and CRC error together
        run("R9", build(8'hA6, 8'h00, 8'hFF, 64, 11, 8'h22), 1'b0);
        // R10: back-to-back frames, second starts right after rx_eof
        tag = "R10";
        send(build(8'hA6, 8'hF0, 8'hFF, 64, 12, 8'h00), 1'b0);
        send(build(8'hA6, 8'hF0, 8'hFF, 64, 13, 8'h00), 1'b0);
        close_frame();
        check_mem("R10");
        // R2: final accepted frame after rejected ones
        run("R2", build(8'hA6, 8'hF0, 8'hFF, 64, 14, 8'h00), 1'b1);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule